// File: doc/BRIEF.md
# Per-CPU Level Interrupt Router

This block gathers a wide set of active-high, level-sensitive peripheral interrupt lines and turns them into one interrupt request per CPU. Every CPU owns a private bank of mask words. A source reaches a CPU only when that CPU's bank has the source's bit set, so one source can be sent to any subset of CPUs by setting its bit in several banks.

Software reaches the banks through a small word-wide register port. Each CPU has its own 32-byte window. Mask words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C of the window. Pending words sit at 0x10, 0x14, 0x18 and 0x1C. Address bit 5 picks the CPU. The block has no priority logic and no queue, so an interrupt handler reads every pending word of its window to learn which sources are active.

The block has no control state machine. Each bank is a set of registers, and the port is decoded in a single cycle.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset every mask word reads 0, `cpu_irq` is 0 and `bus_rdata` is 0.
- R2: A read request (`bus_sel`=1, `bus_we`=0) returns its word on `bus_rdata` one clock later. In every cycle that does not follow a read request, `bus_rdata` is 0. A write to a mask word (window offset 0x00 + 4·k) replaces the whole 32-bit word with `bus_wdata`, and that word reads back unchanged.
- R3: The pending word at window offset 0x10 + 4·k reads as input bits [32k+31:32k] ANDed with mask word k of the same CPU, sampled on the read cycle.
- R4: Writes to a pending word change no mask word and no pending value.
- R5: `cpu_irq[c]` is the OR of all unmasked inputs for CPU c, registered once. It rises one clock after the cause appears and falls one clock after the input drops or its mask bit is cleared.
- R6: `bus_addr[5]` selects the CPU window. A write into one window leaves the other CPU's mask words unchanged.
- R7: Word index k = `bus_addr[3:2]` counts only while k < N_SRC/32. For a larger k, reads return 0 and writes are dropped.
- R8: Inputs are levels with no memory. A pending bit and its output drop as soon as the input is low again, whatever pulse came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address: bit 5 CPU, bit 4 pending/mask, bits 3:2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_src | input | N_SRC | Active-high level interrupt inputs |
| cpu_irq | output | N_CPU | One interrupt request per CPU |

## Verification
The assertions rely on three conditions on the inputs. `irq_src` and the bus signals must hold known values from reset onward. `bus_sel` must be low during reset. Each access must last one cycle with a stable address. The bench drives every input on the falling clock edge, holds `bus_sel` low through reset, and releases each request after one cycle. It uses a 64-input, two-CPU build so that unused word indices exist, and it walks a single set bit across all inputs against fixed, distinct masks for each CPU.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int WORD_W     = 32;
    localparam int WIN_ADDR_W = 6;
    localparam int MAX_WORDS  = 4;
    localparam int WIDX_W     = 2;

    typedef enum logic {
        REG_MASK    = 1'b0,
        REG_PENDING = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic              cpu;
        reg_kind_e         kind;
        logic [WIDX_W-1:0] word;
    } reg_addr_t;
endpackage

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
    import lvl_irq_pkg::*;
#(
    parameter int N_SRC = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIDX_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [N_SRC-1:0]     irq_src,
    output logic [N_SRC-1:0]     mask_q,
    output logic [N_SRC-1:0]     pending,
    output logic                 irq_q
);
    localparam int N_WORDS = N_SRC / WORD_W;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[w*WORD_W +: WORD_W] <= '0;
            end else if (wr_en && (wr_word == WIDX_W'(w))) begin
                mask_q[w*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    assign pending = irq_src & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pending;
        end
    end
endmodule

// File: rtl/lvl_irq_rdmux.sv
module lvl_irq_rdmux
    import lvl_irq_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int N_CPU = 2
) (
    input  reg_addr_t                 sel_addr,
    input  logic [N_CPU*N_SRC-1:0]    mask_all,
    input  logic [N_CPU*N_SRC-1:0]    pend_all,
    output logic [WORD_W-1:0]         word_out
);
    localparam int N_WORDS = N_SRC / WORD_W;

    always_comb begin
        word_out = '0;
        for (int c = 0; c < N_CPU; c++) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (sel_addr.cpu == 1'(c) && sel_addr.word == WIDX_W'(w)) begin
                    if (sel_addr.kind == REG_PENDING) begin
                        word_out = pend_all[c*N_SRC + w*WORD_W +: WORD_W];
                    end else begin
                        word_out = mask_all[c*N_SRC + w*WORD_W +: WORD_W];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
    import lvl_irq_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int N_CPU = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [5:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [N_SRC-1:0]      irq_src,
    output logic [N_CPU-1:0]      cpu_irq
);
    localparam int N_WORDS = N_SRC / WORD_W;

    reg_addr_t                 dec;
    logic                      cpu_ok;
    logic                      word_ok;
    logic [N_CPU*N_SRC-1:0]    mask_all;
    logic [N_CPU*N_SRC-1:0]    pend_all;
    logic [WORD_W-1:0]         mux_word;

    assign dec     = reg_addr_t'(bus_addr[5:2]);
    assign cpu_ok  = (N_CPU > 1) || (dec.cpu == 1'b0);
    assign word_ok = (int'(dec.word) < N_WORDS);

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic wr_hit;
        assign wr_hit = bus_sel && bus_we && cpu_ok && word_ok
                        && (dec.kind == REG_MASK) && (dec.cpu == 1'(c));

        lvl_irq_bank #(.N_SRC(N_SRC)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_word (dec.word),
            .wr_data (bus_wdata),
            .irq_src (irq_src),
            .mask_q  (mask_all[c*N_SRC +: N_SRC]),
            .pending (pend_all[c*N_SRC +: N_SRC]),
            .irq_q   (cpu_irq[c])
        );
    end

    lvl_irq_rdmux #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_rdmux (
        .sel_addr (dec),
        .mask_all (mask_all),
        .pend_all (pend_all),
        .word_out (mux_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_we && cpu_ok) begin
            bus_rdata <= mux_word;
        end else begin
            bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
    parameter int N_SRC = 128,
    parameter int N_CPU = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [5:0]            bus_addr,
    input logic [31:0]           bus_rdata,
    input logic [N_SRC-1:0]      irq_src,
    input logic [N_CPU-1:0]      cpu_irq,
    input logic [N_CPU*N_SRC-1:0] mask_all
);
    localparam int N_WORDS = N_SRC / 32;

    // R1: with every mask clear, no request can appear in the next cycle
    p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all == '0) |=> (cpu_irq == '0));

    // R2: read data is zero unless a read was requested in the previous cycle
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_we) |-> (bus_rdata == '0));

    // R4: a write into the pending half leaves all masks as they were
    p_pending_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && bus_we && bus_addr[4]) |-> $stable(mask_all));

    // R5, R8: quiet inputs give quiet outputs one cycle later
    p_idle_inputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_src) == '0) |-> (cpu_irq == '0));

    // R7: writes to word indices past the implemented ones are dropped
    p_unused_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && bus_we && (int'(bus_addr[3:2]) >= N_WORDS)) |-> $stable(mask_all));

    // R6: a write aimed at another CPU window leaves this bank untouched
    for (genvar c = 0; c < N_CPU; c++) begin : g_iso
        p_bank_isolation_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_sel && bus_we && (bus_addr[5] != 1'(c)))
            |-> $stable(mask_all[c*N_SRC +: N_SRC]));
    end
endmodule

bind lvl_irq_router lvl_irq_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .cpu_irq   (cpu_irq),
    .mask_all  (mask_all)
);

// File: tb/test_lvl_irq_router.sv
module test_lvl_irq_router;
    localparam int NS = 64;
    localparam int NC = 2;
    localparam int NW = NS / 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_sel, bus_we;
    logic [5:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] irq_src;
    logic [NC-1:0] cpu_irq;

    always #4 clk = ~clk;

    lvl_irq_router #(.N_SRC(NS), .N_CPU(NC)) i_lvl_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .cpu_irq(cpu_irq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] mdl [NC][4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] a_mask(input int c, input int w);
        return 6'(c * 32 + w * 4);
    endfunction

    function automatic logic [5:0] a_pend(input int c, input int w);
        return 6'(c * 32 + 16 + w * 4);
    endfunction

    function automatic logic [31:0] exp_pend(input int c, input int w);
        if (w >= NW) return 32'h0;
        return irq_src[w*32 +: 32] & mdl[c][w];
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
                if ((irq_src[w*32 +: 32] & mdl[c][w]) != 0) r[c] = 1'b1;
        return r;
    endfunction

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (a[4] == 1'b0 && int'(a[3:2]) < NW) mdl[a[5]][a[3:2]] = d;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        for (int c = 0; c < NC; c++) for (int w = 0; w < 4; w++) mdl[c][w] = 32'h0;
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 cpu_irq", 32'(cpu_irq), 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 4; w++) begin
                bus_rd(a_mask(c, w), rd);
                check("R1 mask reset", rd, 32'h0);
            end

        // R2/R7: whole-word writes, CPU0 first then CPU1
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 4; w++)
                bus_wr(a_mask(c, w), 32'h9E37_79B9 * (c * 4 + w + 1));
        @(negedge clk);
        check("R2 rdata idle", bus_rdata, 32'h0);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 4; w++) begin
                bus_rd(a_mask(c, w), rd);
                if (w >= NW) check("R7 unused mask word", rd, 32'h0);
                else if (c == 0) check("R6 cpu0 kept after cpu1 writes", rd, mdl[c][w]);
                else check("R2 mask readback", rd, mdl[c][w]);
            end

        // Fixed, distinct masks per CPU for the walking sweep
        bus_wr(a_mask(0, 0), 32'h5555_5555);
        bus_wr(a_mask(0, 1), 32'h0000_FFFF);
        bus_wr(a_mask(1, 0), 32'hAAAA_AAAA);
        bus_wr(a_mask(1, 1), 32'hFFFF_0000);

        // R3/R5/R8: walk one set bit across every input
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            irq_src = '0;
            irq_src[i] = 1'b1;
            @(negedge clk);
            check("R5 irq per cpu", 32'(cpu_irq), 32'(exp_irq()));
            for (int c = 0; c < NC; c++)
                for (int w = 0; w < NW; w++) begin
                    bus_rd(a_pend(c, w), rd);
                    check("R3 pending word", rd, exp_pend(c, w));
                end
        end

        // R5/R8: one-cycle pulse, output rises one clock later and falls one clock after drop
        @(negedge clk);
        irq_src = '0;
        @(negedge clk);
        irq_src[0] = 1'b1;
        @(posedge clk); #1;
        check("R5 rise after one clock", 32'(cpu_irq), 32'h1);
        @(negedge clk);
        irq_src = '0;
        @(posedge clk); #1;
        check("R8 fall after input drops", 32'(cpu_irq), 32'h0);
        bus_rd(a_pend(0, 0), rd);
        check("R8 pending not latched", rd, 32'h0);

        // R5: clearing the mask bit removes the request
        @(negedge clk);
        irq_src[1] = 1'b1;
        @(negedge clk);
        check("R5 cpu1 raised", 32'(cpu_irq), 32'h2);
        bus_wr(a_mask(1, 0), 32'h0);
        @(negedge clk);
        check("R5 falls after mask clear", 32'(cpu_irq), 32'h0);

        // R4: writes to pending words are ignored
        irq_src[32] = 1'b1;
        bus_wr(a_pend(0, 0), 32'hFFFF_FFFF);
        bus_wr(a_pend(1, 1), 32'hFFFF_FFFF);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                bus_rd(a_mask(c, w), rd);
                check("R4 mask unchanged", rd, mdl[c][w]);
                bus_rd(a_pend(c, w), rd);
                check("R4 pending unchanged", rd, exp_pend(c, w));
            end

        // R7: unused pending word reads zero even with active inputs
        irq_src = '1;
        bus_rd(a_pend(0, 2), rd);
        check("R7 unused pending word", rd, 32'h0);
        bus_rd(a_pend(1, 3), rd);
        check("R7 unused pending word", rd, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule